// File: doc/BRIEF.md
# State-Enable CSR Access Checker

This block decides, in one combinational step, whether an access to a CSR protected by a state-enable bit may go ahead. It takes the current privilege level, the virtualization flag, the three enable registers (machine, hypervisor and supervisor level), the index of the guarding bit and two feature flags. From these it returns a two-bit verdict: allow, illegal-instruction or virtual-instruction fault.

The levels are checked from the top down. The machine level is checked first, then the hypervisor level when the hart is virtualized, then the supervisor level at user privilege. The top bit of each enable register is a master switch. When the master switch at one level is clear, every enable below that level reads as zero. The CSR decoder places the block next to the access path and passes the verdict to the trap logic. The block stores no register state and raises no trap itself.

Top module: `stateen_access_check`

## Requirements
- R1: When `privLvl` is 2'b11 (machine), `result` is 2'b00 (allow), whatever the other inputs are.
- R2: When `stateEnSupported` is 0, `result` is 2'b00.
- R3: Outside machine mode, with support present, a clear bit `bitIdx` in `mEnable` gives 2'b01 (illegal-instruction). This outranks every other fault.
- R4: When bit 63 of `mEnable` is clear, `hEnable` and `sEnable` act as all zeros for the later checks.
- R5: When `virtMode` is 1 and the effective `hEnable` has bit `bitIdx` clear, `result` is 2'b10 (virtual-instruction fault).
- R6: When `virtMode` is 1 and bit 63 of the effective `hEnable` is clear, `sEnable` acts as all zeros.
- R7: At user privilege (`privLvl` 2'b00) with `supvExtPresent` 1, a clear bit `bitIdx` in the effective `sEnable` gives 2'b01. This applies virtualized or not, once the earlier checks pass.
- R8: At user privilege with `supvExtPresent` 0, `sEnable` has no effect on `result`.
- R9: At supervisor privilege (`privLvl` 2'b01) with `virtMode` 0, only `mEnable` matters. `hEnable` and `sEnable` have no effect.
- R10: If no check trips, `result` is 2'b00. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| privLvl | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine (10 handled as supervisor) |
| virtMode | input | 1 | Hart runs virtualized |
| mEnable | input | 64 | Machine-level enable register |
| hEnable | input | 64 | Hypervisor-level enable register |
| sEnable | input | 64 | Supervisor-level enable register |
| bitIdx | input | 6 | Index of the guarding bit |
| stateEnSupported | input | 1 | State-enable support present |
| supvExtPresent | input | 1 | Supervisor extension present |
| result | output | 2 | 00 allow, 01 illegal-instruction, 10 virtual-instruction fault |

## Verification
Two things can act on one access at once: the master-bit masking that forces lower registers to zero, and the guarded-bit test at those same lower levels. The bench forces both together. It sets a guarded bit in `hEnable` or `sEnable` while clearing the master bit above it, and it picks index 63, where the guarded bit and the master bit are the same bit. The expected verdict comes from a reference function that applies the masking before the test. A design that tests first and masks afterwards therefore gives a different value.

// File: rtl/stateen_access_pkg.sv
package stateen_access_pkg;
  localparam int unsigned XLEN_DEF = 64;

  typedef enum logic [1:0] {
    ACC_OK      = 2'b00,
    ACC_ILLEGAL = 2'b01,
    ACC_VIRT    = 2'b10
  } accResult_t;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  // Per-level bits the datapath hands to the control after masking
  typedef struct packed {
    logic mBit;     // guarded bit, machine level
    logic hBit;     // guarded bit, hypervisor level, machine-masked
    logic hMaster;  // hypervisor master bit, machine-masked
    logic sBit;     // guarded bit, supervisor level, machine-masked
  } stenStrobes_t;
endpackage

// File: rtl/stateen_access_dp.sv
module stateen_access_dp
  import stateen_access_pkg::*;
#(
  parameter int unsigned XLEN = XLEN_DEF,
  localparam int unsigned IDX_W = $clog2(XLEN),
  localparam int unsigned MASTER_POS = XLEN - 1
) (
  input  logic [XLEN-1:0]  mEnable,
  input  logic [XLEN-1:0]  hEnable,
  input  logic [XLEN-1:0]  sEnable,
  input  logic [IDX_W-1:0] bitIdx,
  output stenStrobes_t     strobes
);
  logic            mMaster;
  logic [XLEN-1:0] hGated;
  logic [XLEN-1:0] sGated;

  assign mMaster = mEnable[MASTER_POS];

  // Lane-wise gating of the lower levels by the machine master bit
  for (genvar lane = 0; lane < XLEN; lane++) begin : g_gate
    assign hGated[lane] = hEnable[lane] & mMaster;
    assign sGated[lane] = sEnable[lane] & mMaster;
  end

  always_comb begin
    strobes.mBit    = mEnable[bitIdx];
    strobes.hBit    = hGated[bitIdx];
    strobes.hMaster = hGated[MASTER_POS];
    strobes.sBit    = sGated[bitIdx];
  end
endmodule

// File: rtl/stateen_access_ctrl.sv
module stateen_access_ctrl
  import stateen_access_pkg::*;
(
  input  logic [1:0]   privLvl,
  input  logic         virtMode,
  input  logic         stateEnSupported,
  input  logic         supvExtPresent,
  input  stenStrobes_t strobes,
  output accResult_t   verdict
);
  logic bypass;
  logic userCheck;
  logic sVisible;

  assign bypass    = (privLvl == PRIV_M) || !stateEnSupported;
  assign userCheck = (privLvl == PRIV_U) && supvExtPresent;
  // When virtualized, a clear hypervisor master hides the supervisor level
  assign sVisible  = strobes.sBit && (!virtMode || strobes.hMaster);

  always_comb begin
    verdict = ACC_OK;
    if (!bypass) begin
      if (!strobes.mBit) begin
        verdict = ACC_ILLEGAL;
      end else if (virtMode && !strobes.hBit) begin
        verdict = ACC_VIRT;
      end else if (userCheck && !sVisible) begin
        verdict = ACC_ILLEGAL;
      end
    end
  end
endmodule

// File: rtl/stateen_access_check.sv
module stateen_access_check
  import stateen_access_pkg::*;
#(
  parameter int unsigned XLEN = XLEN_DEF,
  localparam int unsigned IDX_W = $clog2(XLEN)
) (
  input  logic [1:0]       privLvl,
  input  logic             virtMode,
  input  logic [XLEN-1:0]  mEnable,
  input  logic [XLEN-1:0]  hEnable,
  input  logic [XLEN-1:0]  sEnable,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic             stateEnSupported,
  input  logic             supvExtPresent,
  output logic [1:0]       result
);
  stenStrobes_t strobes;
  accResult_t   verdict;

  stateen_access_dp #(.XLEN(XLEN)) u_dp (
    .mEnable (mEnable),
    .hEnable (hEnable),
    .sEnable (sEnable),
    .bitIdx  (bitIdx),
    .strobes (strobes)
  );

  stateen_access_ctrl u_ctrl (
    .privLvl          (privLvl),
    .virtMode         (virtMode),
    .stateEnSupported (stateEnSupported),
    .supvExtPresent   (supvExtPresent),
    .strobes          (strobes),
    .verdict          (verdict)
  );

  assign result = verdict;
endmodule

// File: rtl/stateen_access_check_sva.sv
module stateen_access_check_sva #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned IDX_W = $clog2(XLEN)
) (
  input logic [1:0]       privLvl,
  input logic             virtMode,
  input logic [XLEN-1:0]  mEnable,
  input logic [XLEN-1:0]  hEnable,
  input logic [XLEN-1:0]  sEnable,
  input logic [IDX_W-1:0] bitIdx,
  input logic             stateEnSupported,
  input logic             supvExtPresent,
  input logic [1:0]       result
);
  logic active;
  assign active = stateEnSupported && (privLvl != 2'b11);

  always_comb begin
    p_machine_allow_r1: assert (privLvl != 2'b11 || result == 2'b00)
      else $error("machine mode not allowed");
    p_unsupported_allow_r2: assert (stateEnSupported || result == 2'b00)
      else $error("unsupported not allowed");
    p_mbit_illegal_r3: assert (!active || mEnable[bitIdx] || result == 2'b01)
      else $error("machine bit clear without illegal");
    p_mmaster_hides_h_r4: assert (!(active && virtMode && mEnable[bitIdx]
        && !mEnable[XLEN-1]) || result == 2'b10)
      else $error("machine master did not hide hypervisor level");
    p_hbit_virt_r5: assert (!(active && virtMode && mEnable[bitIdx]
        && !hEnable[bitIdx]) || result == 2'b10)
      else $error("hypervisor bit clear without virtual fault");
    p_no_code3_r10: assert (result != 2'b11)
      else $error("reserved result code");
  end
endmodule

bind stateen_access_check stateen_access_check_sva #(.XLEN(XLEN)) u_sva (
  .privLvl          (privLvl),
  .virtMode         (virtMode),
  .mEnable          (mEnable),
  .hEnable          (hEnable),
  .sEnable          (sEnable),
  .bitIdx           (bitIdx),
  .stateEnSupported (stateEnSupported),
  .supvExtPresent   (supvExtPresent),
  .result           (result)
);

// File: tb/stateen_access_check_test.sv
`timescale 1ns/1ps
module stateen_access_check_test;
  logic        clk = 1'b0;
  logic [1:0]  privLvl;
  logic        virtMode;
  logic [63:0] mEnable, hEnable, sEnable;
  logic [5:0]  bitIdx;
  logic        stateEnSupported, supvExtPresent;
  logic [1:0]  result;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stateen_access_check uut (
    .privLvl(privLvl), .virtMode(virtMode), .mEnable(mEnable),
    .hEnable(hEnable), .sEnable(sEnable), .bitIdx(bitIdx),
    .stateEnSupported(stateEnSupported), .supvExtPresent(supvExtPresent),
    .result(result)
  );

  function automatic logic [1:0] refResult(
    logic [1:0] pl, logic vm, logic [63:0] m, logic [63:0] h,
    logic [63:0] s, logic [5:0] idx, logic sup, logic sx);
    logic [63:0] he, se;
    if (pl == 2'b11 || !sup) return 2'b00;
    if (!m[idx]) return 2'b01;
    he = m[63] ? h : 64'd0;
    se = m[63] ? s : 64'd0;
    if (vm) begin
      if (!he[idx]) return 2'b10;
      if (!he[63]) se = 64'd0;
    end
    if (pl == 2'b00 && sx && !se[idx]) return 2'b01;
    return 2'b00;
  endfunction

  task automatic apply(string tag, logic [1:0] pl, logic vm, logic [63:0] m,
                       logic [63:0] h, logic [63:0] s, logic [5:0] idx,
                       logic sup, logic sx, logic [1:0] expd);
    @(posedge clk);
    privLvl = pl; virtMode = vm; mEnable = m; hEnable = h; sEnable = s;
    bitIdx = idx; stateEnSupported = sup; supvExtPresent = sx;
    @(negedge clk);
    checks++;
    if (result !== expd) begin
      failures++;
      $display("FAIL %s: result=%b expected=%b", tag, result, expd);
    end
  endtask

  localparam logic [63:0] ALL = '1;

  initial begin
    apply("R2 reset-like zero inputs", 2'b00, 0, 0, 0, 0, 0, 0, 0, 2'b00);
    apply("R1 machine ignores zeros", 2'b11, 1, 0, 0, 0, 6'd5, 1, 1, 2'b00);
    apply("R2 unsupported", 2'b00, 1, 0, 0, 0, 6'd5, 0, 1, 2'b00);
    apply("R3 machine bit clear beats virt", 2'b00, 1, ALL & ~(64'd1 << 7),
          0, 0, 6'd7, 1, 1, 2'b01);
    apply("R4 m master hides h", 2'b01, 1, 64'h0000_0000_0000_0080,
          ALL, ALL, 6'd7, 1, 1, 2'b10);
    apply("R4 m master hides s", 2'b00, 0, 64'h0000_0000_0000_0080,
          ALL, ALL, 6'd7, 1, 1, 2'b01);
    apply("R5 h bit clear", 2'b01, 1, ALL, ALL & ~(64'd1 << 3), ALL,
          6'd3, 1, 1, 2'b10);
    apply("R6 h master hides s", 2'b00, 1, ALL, 64'h0000_0000_0000_0008,
          ALL, 6'd3, 1, 1, 2'b01);
    apply("R6 h master irrelevant non-virt", 2'b00, 0, ALL, 0, ALL,
          6'd3, 1, 1, 2'b00);
    apply("R7 s bit clear user", 2'b00, 0, ALL, ALL, ALL & ~(64'd1 << 9),
          6'd9, 1, 1, 2'b01);
    apply("R7 s bit clear virt user", 2'b00, 1, ALL, ALL, ALL & ~(64'd1 << 9),
          6'd9, 1, 1, 2'b01);
    apply("R8 no supv ext", 2'b00, 0, ALL, 0, 0, 6'd9, 1, 0, 2'b00);
    apply("R9 supervisor non-virt", 2'b01, 0, ALL, 0, 0, 6'd20, 1, 1, 2'b00);
    apply("R10 all set allow", 2'b00, 1, ALL, ALL, ALL, 6'd63, 1, 1, 2'b00);
    apply("R4 index 63 m master", 2'b01, 0, ALL >> 1, ALL, ALL, 6'd63, 1, 1,
          2'b01);
    apply("R6 index 63 h master", 2'b01, 1, ALL, ALL >> 1, ALL, 6'd63, 1, 1,
          2'b10);
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] pl; logic vm, sup, sx; logic [63:0] m, h, s; logic [5:0] ix;
      pl = 2'($urandom);
      vm = 1'($urandom);
      sup = ($urandom % 8) != 0;
      sx = ($urandom % 4) != 0;
      m = {$urandom, $urandom} | {$urandom, $urandom};
      h = {$urandom, $urandom} | {$urandom, $urandom};
      s = {$urandom, $urandom} | {$urandom, $urandom};
      ix = ($urandom % 5 == 0) ? 6'd63 : 6'($urandom);
      apply("R10 random vs reference", pl, vm, m, h, s, ix, sup, sx,
            refResult(pl, vm, m, h, s, ix, sup, sx));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: result=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule